// File: doc/BRIEF.md
# Downstream Hub Port Power and Status Manager

This block looks after power and connect signalling for the four downstream ports of a hub. Each port has an active-low overcurrent flag coming in from its external power switch, an active-low power-switch enable going out, and an active-low connect indicator going out. Overcurrent flags are synchronized, then filtered by a run-length counter whose length software sets. A port whose flag stays asserted for that long is tripped. A tripped port loses its power and its enable, and it stays dark until a fresh power-on command arrives while its flag is clear. Every other port keeps running untouched.

The block exposes readable status for the hub's register interface: whether each port is powered, enabled and in overcurrent, plus sticky change bits for overcurrent and enable transitions. Software clears those bits with write-one-to-clear strobes. A mode strap selects self-powered (high) or bus-powered (low) operation. Only in self-powered mode is the local-supply-good flag reported, along with its own sticky change bit. In bus-powered mode the local-supply status reads as not applicable and its toggles are ignored.

Top module: `hub_port_pwr_mgr`

## Requirements
- R1: A qualified overcurrent on port i turns off that port's power switch (`pwr_sw_n[i]` goes to 1) on the clock edge after `port_oc[i]` rises, and no other port's power switch changes.
- R2: After `oc_n[i]` falls, with `eff` equal to `oc_filter_len` (or 1 when that field is 0), `pwr_sw_n[i]` is still 0 after eff+2 rising edges and is 1 after eff+3. A low pulse shorter than `eff` cycles never trips the port and leaves `port_oc` and `oc_chg` at 0.
- R3: A filter length of 0 acts exactly like a length of 1.
- R4: A port can be enabled only while it is powered. A trip clears the port's enable on the same edge that removes its power.
- R5: Out of reset every port is unpowered. An unpowered port stays unpowered until the edge that samples `pwr_on_cmd[i]` high while its synchronized overcurrent flag is clear. A command issued while the flag is still asserted is ignored.
- R6: `conn_stat_n[i]` is 0 exactly while the port is enabled. The port is enabled when `port_en_req[i]` is high and the port is powered. This takes effect on the edge that samples the request.
- R7: `oc_chg[i]` sets one edge after any change of `port_oc[i]`, in either direction, and stays set until it is cleared.
- R8: `en_chg[i]` sets on the same edge as any change of `port_enabled[i]`.
- R9: A 1 on `oc_chg_clr[i]`, `en_chg_clr[i]` or `lp_chg_clr` for one cycle clears the matching sticky bit at that edge.
- R10: `port_oc[i]` is 1 while the filtered overcurrent is asserted. It returns to 0 a fixed three edges after `oc_n[i]` rises.
- R11: With the mode strap high, `lp_valid` is 1 and `lp_good_stat` follows `local_pwr_good` three edges later. With the strap low, both read 0 whatever `local_pwr_good` does.
- R12: `lp_chg` sets when the synchronized local-supply flag changes while in self-powered mode. In bus-powered mode a toggle of `local_pwr_good` leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_n | input | NPORTS | Per-port overcurrent flag, active low, asynchronous |
| self_pwr_mode | input | 1 | Mode strap: 1 self-powered, 0 bus-powered |
| local_pwr_good | input | 1 | Local supply good flag, asynchronous |
| port_en_req | input | NPORTS | Per-port enable request from hub controller |
| pwr_on_cmd | input | NPORTS | Per-port power-on command pulse |
| oc_filter_len | input | FILT_W | Overcurrent qualification length in cycles (0 acts as 1) |
| oc_chg_clr | input | NPORTS | Write-one-to-clear strobes for overcurrent change bits |
| en_chg_clr | input | NPORTS | Write-one-to-clear strobes for enable change bits |
| lp_chg_clr | input | 1 | Write-one-to-clear strobe for the local power change bit |
| pwr_sw_n | output | NPORTS | Per-port power switch enable, active low |
| conn_stat_n | output | NPORTS | Per-port connect indicator, active low |
| port_powered | output | NPORTS | Port power status |
| port_enabled | output | NPORTS | Port enable status |
| port_oc | output | NPORTS | Filtered overcurrent status |
| oc_chg | output | NPORTS | Sticky overcurrent change bits |
| en_chg | output | NPORTS | Sticky enable change bits |
| lp_valid | output | 1 | Local supply status applicable (self-powered mode) |
| lp_good_stat | output | 1 | Reported local supply good |
| lp_chg | output | 1 | Sticky local power change bit |

## Verification
The hardest state to reach from the ports is a tripped port whose flag has already cleared but which has not yet been re-powered. Reaching it needs a qualified overcurrent, then an ignored power-on command while the flag is still low, then the flag's release, all without disturbing the other three ports. The bench builds that sequence for every port and for each of the filter lengths 0, 1, 2 and 4. It times the trip edge exactly and first sends a one-cycle-short glitch that must not trip the port. The local-supply reporting is swept over both strap levels and both flag directions.

// File: rtl/hub_pwr_pkg.sv
package hub_pwr_pkg;
  // Effective qualification length minus one; a zero setting behaves like one.
  function automatic int unsigned filt_last(input int unsigned len);
    return (len == 0) ? 0 : len - 1;
  endfunction
endpackage

// File: rtl/hub_sync2.sv
module hub_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hub_oc_filter.sv
module hub_oc_filter #(
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oc_s,
  input  logic [FILT_W-1:0] len,
  output logic              qual
);
  import hub_pwr_pkg::*;

  logic [FILT_W-1:0] run;
  logic [FILT_W-1:0] last;

  assign last = FILT_W'(filt_last(int'(len)));

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      qual <= 1'b0;
    end else if (!oc_s) begin
      run  <= '0;
      qual <= 1'b0;
    end else if (run >= last) begin
      qual <= 1'b1;
    end else begin
      run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/hub_port_ctrl.sv
module hub_port_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic qual,
  input  logic oc_s,
  input  logic pwr_on,
  input  logic en_req,
  input  logic oc_clr,
  input  logic en_clr,
  output logic powered,
  output logic enabled,
  output logic oc_chg,
  output logic en_chg
);
  logic qual_d;
  logic pw_next;
  logic en_next;

  always_comb begin
    pw_next = powered;
    if (qual)
      pw_next = 1'b0;
    else if (pwr_on && !oc_s)
      pw_next = 1'b1;
    en_next = en_req && pw_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      powered <= 1'b0;
      enabled <= 1'b0;
      qual_d  <= 1'b0;
      oc_chg  <= 1'b0;
      en_chg  <= 1'b0;
    end else begin
      powered <= pw_next;
      enabled <= en_next;
      qual_d  <= qual;
      if (qual != qual_d)
        oc_chg <= 1'b1;
      else if (oc_clr)
        oc_chg <= 1'b0;
      if (en_next != enabled)
        en_chg <= 1'b1;
      else if (en_clr)
        en_chg <= 1'b0;
    end
  end
endmodule

// File: rtl/hub_local_pwr.sv
module hub_local_pwr (
  input  logic clk,
  input  logic rst,
  input  logic mode_s,
  input  logic lp_s,
  input  logic clr,
  output logic valid,
  output logic good,
  output logic chg
);
  logic lp_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_prev <= 1'b0;
      valid   <= 1'b0;
      good    <= 1'b0;
      chg     <= 1'b0;
    end else begin
      lp_prev <= lp_s;
      valid   <= mode_s;
      good    <= mode_s && lp_s;
      if (mode_s && (lp_s != lp_prev))
        chg <= 1'b1;
      else if (clr)
        chg <= 1'b0;
    end
  end
endmodule

// File: rtl/hub_port_pwr_mgr.sv
module hub_port_pwr_mgr #(
  parameter int NPORTS = 4,
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] oc_n,
  input  logic              self_pwr_mode,
  input  logic              local_pwr_good,
  input  logic [NPORTS-1:0] port_en_req,
  input  logic [NPORTS-1:0] pwr_on_cmd,
  input  logic [FILT_W-1:0] oc_filter_len,
  input  logic [NPORTS-1:0] oc_chg_clr,
  input  logic [NPORTS-1:0] en_chg_clr,
  input  logic              lp_chg_clr,
  output logic [NPORTS-1:0] pwr_sw_n,
  output logic [NPORTS-1:0] conn_stat_n,
  output logic [NPORTS-1:0] port_powered,
  output logic [NPORTS-1:0] port_enabled,
  output logic [NPORTS-1:0] port_oc,
  output logic [NPORTS-1:0] oc_chg,
  output logic [NPORTS-1:0] en_chg,
  output logic              lp_valid,
  output logic              lp_good_stat,
  output logic              lp_chg
);
  localparam int SW = NPORTS + 2;

  logic [SW-1:0]     raw_in;
  logic [SW-1:0]     sync_out;
  logic [NPORTS-1:0] oc_s;
  logic              mode_s;
  logic              lp_s;

  assign raw_in = {self_pwr_mode, local_pwr_good, ~oc_n};

  hub_sync2 #(.W(SW)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_out)
  );

  assign oc_s   = sync_out[NPORTS-1:0];
  assign lp_s   = sync_out[NPORTS];
  assign mode_s = sync_out[NPORTS+1];

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    hub_oc_filter #(.FILT_W(FILT_W)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .oc_s (oc_s[i]),
      .len  (oc_filter_len),
      .qual (port_oc[i])
    );

    hub_port_ctrl u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .qual    (port_oc[i]),
      .oc_s    (oc_s[i]),
      .pwr_on  (pwr_on_cmd[i]),
      .en_req  (port_en_req[i]),
      .oc_clr  (oc_chg_clr[i]),
      .en_clr  (en_chg_clr[i]),
      .powered (port_powered[i]),
      .enabled (port_enabled[i]),
      .oc_chg  (oc_chg[i]),
      .en_chg  (en_chg[i])
    );
  end

  assign pwr_sw_n    = ~port_powered;
  assign conn_stat_n = ~port_enabled;

  hub_local_pwr u_lp (
    .clk    (clk),
    .rst    (rst),
    .mode_s (mode_s),
    .lp_s   (lp_s),
    .clr    (lp_chg_clr),
    .valid  (lp_valid),
    .good   (lp_good_stat),
    .chg    (lp_chg)
  );
endmodule

// File: rtl/hub_port_pwr_chk.sv
module hub_port_pwr_chk #(
  parameter int NPORTS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NPORTS-1:0] pwr_sw_n,
  input logic [NPORTS-1:0] pwr_on_cmd,
  input logic [NPORTS-1:0] port_enabled,
  input logic [NPORTS-1:0] port_oc,
  input logic [NPORTS-1:0] oc_chg,
  input logic [NPORTS-1:0] en_chg,
  input logic              lp_valid,
  input logic              lp_good_stat
);
  for (genvar i = 0; i < NPORTS; i++) begin : g_chk
    assert_oc_cuts_power_R1: assert property (@(posedge clk) disable iff (rst)
      port_oc[i] |=> pwr_sw_n[i]);

    assert_enable_needs_power_R4: assert property (@(posedge clk) disable iff (rst)
      port_enabled[i] |-> !pwr_sw_n[i]);

    assert_off_holds_R5: assert property (@(posedge clk) disable iff (rst)
      (pwr_sw_n[i] && !pwr_on_cmd[i]) |=> pwr_sw_n[i]);

    assert_oc_change_sets_R7: assert property (@(posedge clk) disable iff (rst)
      ($past(port_oc[i]) != port_oc[i]) |=> oc_chg[i]);

    assert_en_change_sets_R8: assert property (@(posedge clk) disable iff (rst)
      ($past(port_enabled[i]) != port_enabled[i]) |-> en_chg[i]);
  end

  assert_bus_mode_no_lp_R11: assert property (@(posedge clk) disable iff (rst)
    !lp_valid |-> !lp_good_stat);
endmodule

bind hub_port_pwr_mgr hub_port_pwr_chk #(.NPORTS(NPORTS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pwr_sw_n     (pwr_sw_n),
  .pwr_on_cmd   (pwr_on_cmd),
  .port_enabled (port_enabled),
  .port_oc      (port_oc),
  .oc_chg       (oc_chg),
  .en_chg       (en_chg),
  .lp_valid     (lp_valid),
  .lp_good_stat (lp_good_stat)
);

// File: tb/tb_hub_port_pwr_mgr.sv
`timescale 1ns/1ps
module tb_hub_port_pwr_mgr;
  localparam int NP = 4;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] oc_n = '1;
  logic          self_pwr_mode = 1'b0;
  logic          local_pwr_good = 1'b0;
  logic [NP-1:0] port_en_req = '0;
  logic [NP-1:0] pwr_on_cmd = '0;
  logic [FW-1:0] oc_filter_len = '0;
  logic [NP-1:0] oc_chg_clr = '0;
  logic [NP-1:0] en_chg_clr = '0;
  logic          lp_chg_clr = 1'b0;
  logic [NP-1:0] pwr_sw_n, conn_stat_n, port_powered, port_enabled, port_oc, oc_chg, en_chg;
  logic          lp_valid, lp_good_stat, lp_chg;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  hub_port_pwr_mgr #(.NPORTS(NP), .FILT_W(FW)) dut (
    .clk(clk), .rst(rst), .oc_n(oc_n), .self_pwr_mode(self_pwr_mode),
    .local_pwr_good(local_pwr_good), .port_en_req(port_en_req), .pwr_on_cmd(pwr_on_cmd),
    .oc_filter_len(oc_filter_len), .oc_chg_clr(oc_chg_clr), .en_chg_clr(en_chg_clr),
    .lp_chg_clr(lp_chg_clr), .pwr_sw_n(pwr_sw_n), .conn_stat_n(conn_stat_n),
    .port_powered(port_powered), .port_enabled(port_enabled), .port_oc(port_oc),
    .oc_chg(oc_chg), .en_chg(en_chg), .lp_valid(lp_valid), .lp_good_stat(lp_good_stat),
    .lp_chg(lp_chg)
  );

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    oc_chg_clr = '1; en_chg_clr = '1; lp_chg_clr = 1'b1;
    step(1);
    oc_chg_clr = '0; en_chg_clr = '0; lp_chg_clr = 1'b0;
  endtask

  initial begin
    step(1);
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk("R5 reset power", 32'(pwr_sw_n), 32'hF);
    chk("R6 reset conn", 32'(conn_stat_n), 32'hF);
    chk("R7 reset oc_chg", 32'(oc_chg), 0);
    chk("R8 reset en_chg", 32'(en_chg), 0);
    chk("R12 reset lp_chg", 32'(lp_chg), 0);

    pwr_on_cmd = '1; step(1); pwr_on_cmd = '0;
    port_en_req = '1; step(2);
    chk("R5 power on", 32'(pwr_sw_n), 0);
    chk("R6 enabled", 32'(conn_stat_n), 0);
    chk("R8 enable change", 32'(en_chg), 32'hF);
    clear_all();
    chk("R9 en_chg cleared", 32'(en_chg), 0);

    for (int p = 0; p < NP; p++) begin
      for (int li = 0; li < 4; li++) begin
        int len;
        int eff;
        logic [NP-1:0] bit_p;
        len = (li == 3) ? 4 : li;
        eff = (len == 0) ? 1 : len;
        bit_p = NP'(1) << p;
        oc_filter_len = FW'(len);
        if (eff > 1) begin
          oc_n[p] = 1'b0; step(eff - 1); oc_n[p] = 1'b1; step(6);
          chk("R2 glitch no trip", 32'(pwr_sw_n), 0);
          chk("R2 glitch oc", 32'(port_oc), 0);
          chk("R2 glitch oc_chg", 32'(oc_chg), 0);
        end
        oc_n[p] = 1'b0;
        step(eff + 2);
        chk(len == 0 ? "R3 zero len still on" : "R2 still on", 32'(pwr_sw_n), 0);
        step(1);
        chk(len == 0 ? "R3 zero len trip" : "R1 trip this port only", 32'(pwr_sw_n), 32'(bit_p));
        chk("R4 trip disables", 32'(conn_stat_n), 32'(bit_p));
        chk("R10 oc status", 32'(port_oc), 32'(bit_p));
        chk("R7 oc_chg set", 32'(oc_chg), 32'(bit_p));
        chk("R8 en_chg on trip", 32'(en_chg), 32'(bit_p));
        pwr_on_cmd[p] = 1'b1; step(1); pwr_on_cmd[p] = 1'b0; step(2);
        chk("R5 cmd during oc ignored", 32'(pwr_sw_n), 32'(bit_p));
        oc_n[p] = 1'b1; step(3);
        chk("R10 oc cleared", 32'(port_oc), 0);
        step(3);
        chk("R5 stays off", 32'(pwr_sw_n), 32'(bit_p));
        chk("R7 oc_chg held", 32'(oc_chg), 32'(bit_p));
        clear_all();
        chk("R9 oc_chg cleared", 32'(oc_chg), 0);
        chk("R9 en_chg cleared", 32'(en_chg), 0);
        pwr_on_cmd[p] = 1'b1; step(1); pwr_on_cmd[p] = 1'b0;
        chk("R5 repowered", 32'(pwr_sw_n), 0);
        chk("R6 re-enabled", 32'(conn_stat_n), 0);
        chk("R8 en_chg on re-enable", 32'(en_chg), 32'(bit_p));
        clear_all();
      end
      port_en_req[p] = 1'b0; step(1);
      chk("R6 request dropped", 32'(conn_stat_n), 32'(NP'(1) << p));
      chk("R6 power kept", 32'(pwr_sw_n), 0);
      port_en_req[p] = 1'b1; step(1);
      chk("R6 request restored", 32'(conn_stat_n), 0);
      clear_all();
    end

    for (int m = 0; m < 2; m++) begin
      self_pwr_mode = 1'(m);
      local_pwr_good = 1'b0;
      step(4);
      clear_all();
      local_pwr_good = 1'b1; step(2);
      chk("R11 good latency", 32'(lp_good_stat), 0);
      step(1);
      chk("R11 valid", 32'(lp_valid), 32'(m));
      chk("R11 good", 32'(lp_good_stat), 32'(m));
      chk("R12 change rise", 32'(lp_chg), 32'(m));
      clear_all();
      chk("R9 lp_chg cleared", 32'(lp_chg), 0);
      local_pwr_good = 1'b0; step(4);
      chk("R11 good low", 32'(lp_good_stat), 0);
      chk("R12 change fall", 32'(lp_chg), 32'(m));
      clear_all();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule